// File: doc/BRIEF.md
# Register-Write Command Buffer Packer

This block turns a stream of register-write requests into the instruction image that a display programming engine later fetches from memory. Each request carries a 20-bit register offset, a 32-bit value and a flag that selects a direct (single) write or an indexed (auto-increment) write. The block writes the matching instruction words into a word-addressed command RAM through a single write port, one word per clock. Consecutive indexed writes to the same register are folded into one burst: the new value is appended and the count word stored at the start of that instruction is rewritten.

Indexed instructions always begin on an even word, and a zero pad word follows any indexed instruction that ends on an odd position. A commit request closes the buffer. It reports the tail as a byte offset rounded up to a 64-byte line, fills the gap up to the tail with zeros and rewinds the write position to zero. Requests that arrive once the buffer is full are dropped and flagged. Fetching and executing the buffer belong to other blocks.

Top module: `cmd_packer`

## Requirements
- R1: A direct write starting at free position s writes the data at word s and the header {8'h01, 4'hF, offset[19:0]} at word s+1. The free position becomes s+2 and the open indexed run, if any, is closed.
- R2: An indexed write that does not continue the open run rounds the free position up to an even word b. It writes count 1 at b, header {8'h09, 4'h0, offset} at b+1, the data at b+2 and a zero pad at b+3. The free position becomes b+3, and a skipped odd word is left unwritten.
- R3: An indexed write to the offset of the open indexed run writes the data at the free position f and the incremented count at the run's start word. It writes a zero at f+1 when f+1 is odd, and the free position becomes f+1.
- R4: Only an indexed instruction can be extended. A direct write to the same offset ends the run, so a following indexed write to that offset opens a new instruction.
- R5: A request accepted while the free position is at or above 2048 is dropped. It writes nothing, leaves the free position unchanged and sets overflow_o, which stays set until a commit of a non-empty buffer clears it.
- R6: A commit of a non-empty buffer pulses tail_valid_o one cycle after acceptance, with tail_o equal to 4 times the free position rounded up to a multiple of 64 bytes.
- R7: After a commit, every word from the old free position up to, but not including, the tail word holds zero.
- R8: After a commit, the free position is zero and no run is open, so an indexed write opens a new instruction at word 0.
- R9: A commit of an empty buffer writes nothing, gives no tail pulse and changes no state.
- R10: req_ready_o is low while instruction words or fill words are still pending. The first word of an accepted request is on the RAM port in the cycle after acceptance. A commit takes priority over a request presented in the same cycle, and that request is not accepted.
- R11: Out of reset, the free position is 0, req_ready_o is high, and ram_we_o, tail_valid_o and overflow_o are low.
- R12: A word whose position lies at or beyond the 2048-word capacity is never written to the RAM. The lower words of the buffer are left intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Write request present |
| req_indexed_i | input | 1 | 1 selects an indexed write, 0 a direct write |
| req_offset_i | input | 20 | Register offset |
| req_data_i | input | 32 | Register value |
| req_ready_o | output | 1 | Request or commit can be accepted |
| commit_i | input | 1 | Close the buffer and report its tail |
| ram_we_o | output | 1 | Command RAM write enable |
| ram_addr_o | output | 11 | Command RAM word address |
| ram_wdata_o | output | 32 | Command RAM write data |
| free_pos_o | output | 13 | Next free word position |
| tail_o | output | 15 | Tail byte offset, line aligned |
| tail_valid_o | output | 1 | One-cycle pulse when tail_o is updated |
| overflow_o | output | 1 | A request was dropped because the buffer was full |

## Verification
The assertions check the following on every cycle: the step of the free position after a direct write, the drop behaviour on a full buffer, line alignment of the reported tail, rewind after commit, the silent empty commit, and the rule that ready stays low while RAM words are pending. The following are shown only by the bench scenarios, which compare the captured RAM image with a model: the exact word layout of opened and merged indexed instructions, the count rewrites, the even alignment, the zero fill up to the tail, and the fact that writes past capacity leave the low words untouched.

// File: rtl/cmdpk_pkg.sv
package cmdpk_pkg;
  localparam int OFF_W     = 20;
  localparam int DATA_W    = 32;
  localparam int MAX_WORDS = 4;
  localparam int NW_W      = $clog2(MAX_WORDS + 1);
  localparam int IDX_W     = $clog2(MAX_WORDS);

  localparam logic [7:0] OPC_DIRECT  = 8'h01;
  localparam logic [7:0] OPC_INDEXED = 8'h09;
  localparam logic [3:0] BE_ALL      = 4'hF;

  typedef enum logic [1:0] {
    KIND_DROP,
    KIND_DIRECT,
    KIND_MERGE,
    KIND_OPEN
  } req_kind_e;

  function automatic logic [DATA_W-1:0] direct_hdr(input logic [OFF_W-1:0] off);
    return {OPC_DIRECT, BE_ALL, off};
  endfunction

  function automatic logic [DATA_W-1:0] indexed_hdr(input logic [OFF_W-1:0] off);
    return {OPC_INDEXED, 4'h0, off};
  endfunction
endpackage

// File: rtl/cmdpk_planner.sv
module cmdpk_planner
  import cmdpk_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int FP_W  = 13
) (
  input  logic                                  req_indexed_i,
  input  logic [OFF_W-1:0]                      req_offset_i,
  input  logic [DATA_W-1:0]                     req_data_i,
  input  logic [FP_W-1:0]                       free_i,
  input  logic [FP_W-1:0]                       ins_i,
  input  logic                                  cur_valid_i,
  input  logic [OFF_W-1:0]                      cur_off_i,
  input  logic [FP_W-1:0]                       count_i,
  output req_kind_e                             kind_o,
  output logic [NW_W-1:0]                       n_words_o,
  output logic [MAX_WORDS-1:0][FP_W-1:0]        w_addr_o,
  output logic [MAX_WORDS-1:0][DATA_W-1:0]      w_data_o,
  output logic [FP_W-1:0]                       free_nxt_o,
  output logic [FP_W-1:0]                       ins_nxt_o,
  output logic [FP_W-1:0]                       count_nxt_o
);
  logic [FP_W-1:0] base;
  logic [FP_W-1:0] nxt;

  always_comb begin
    kind_o      = KIND_DROP;
    n_words_o   = '0;
    w_addr_o    = '0;
    w_data_o    = '0;
    free_nxt_o  = free_i;
    ins_nxt_o   = ins_i;
    count_nxt_o = count_i;
    base        = free_i + FP_W'(free_i[0]);
    nxt         = free_i + FP_W'(1);
    if (free_i >= FP_W'(DEPTH)) begin
      kind_o = KIND_DROP;
    end else if (!req_indexed_i) begin
      kind_o      = KIND_DIRECT;
      n_words_o   = NW_W'(2);
      w_addr_o[0] = free_i;
      w_data_o[0] = req_data_i;
      w_addr_o[1] = free_i + FP_W'(1);
      w_data_o[1] = direct_hdr(req_offset_i);
      free_nxt_o  = free_i + FP_W'(2);
      ins_nxt_o   = free_i;
    end else if (cur_valid_i && (req_offset_i == cur_off_i)) begin
      // extend open burst: append value, rewrite count at start
      kind_o      = KIND_MERGE;
      count_nxt_o = count_i + FP_W'(1);
      w_addr_o[0] = free_i;
      w_data_o[0] = req_data_i;
      w_addr_o[1] = ins_i;
      w_data_o[1] = DATA_W'(count_nxt_o);
      w_addr_o[2] = nxt;
      w_data_o[2] = '0;
      n_words_o   = nxt[0] ? NW_W'(3) : NW_W'(2);
      free_nxt_o  = nxt;
    end else begin
      kind_o      = KIND_OPEN;
      n_words_o   = NW_W'(4);
      w_addr_o[0] = base;
      w_data_o[0] = DATA_W'(1);
      w_addr_o[1] = base + FP_W'(1);
      w_data_o[1] = indexed_hdr(req_offset_i);
      w_addr_o[2] = base + FP_W'(2);
      w_data_o[2] = req_data_i;
      w_addr_o[3] = base + FP_W'(3);
      w_data_o[3] = '0;
      free_nxt_o  = base + FP_W'(3);
      ins_nxt_o   = base;
      count_nxt_o = FP_W'(1);
    end
  end
endmodule

// File: rtl/cmdpk_word_seq.sv
module cmdpk_word_seq
  import cmdpk_pkg::*;
#(
  parameter int FP_W = 13
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             load_i,
  input  logic [NW_W-1:0]                  n_i,
  input  logic [MAX_WORDS-1:0][FP_W-1:0]   addr_i,
  input  logic [MAX_WORDS-1:0][DATA_W-1:0] data_i,
  output logic                             busy_o,
  output logic [FP_W-1:0]                  addr_o,
  output logic [DATA_W-1:0]                data_o
);
  logic [MAX_WORDS-1:0][FP_W-1:0]   slot_addr_q;
  logic [MAX_WORDS-1:0][DATA_W-1:0] slot_data_q;
  logic [IDX_W-1:0]                 idx_q;
  logic [IDX_W-1:0]                 last_q;
  logic                             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_addr_q <= '0;
      slot_data_q <= '0;
      idx_q       <= '0;
      last_q      <= '0;
      busy_q      <= 1'b0;
    end else if (load_i && (n_i != '0)) begin
      slot_addr_q <= addr_i;
      slot_data_q <= data_i;
      idx_q       <= '0;
      last_q      <= IDX_W'(n_i - NW_W'(1));
      busy_q      <= 1'b1;
    end else if (busy_q) begin
      if (idx_q == last_q) busy_q <= 1'b0;
      else                 idx_q  <= idx_q + IDX_W'(1);
    end
  end

  assign busy_o = busy_q;
  assign addr_o = slot_addr_q[idx_q];
  assign data_o = slot_data_q[idx_q];
endmodule

// File: rtl/cmdpk_line_fill.sv
module cmdpk_line_fill #(
  parameter int FP_W = 13
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [FP_W-1:0] from_i,
  input  logic [FP_W-1:0] to_i,
  output logic            busy_o,
  output logic [FP_W-1:0] addr_o
);
  logic [FP_W-1:0] cur_q;
  logic [FP_W-1:0] end_q;
  logic            busy_q;
  logic [FP_W-1:0] cur_inc;

  assign cur_inc = cur_q + FP_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      end_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      cur_q  <= from_i;
      end_q  <= to_i;
      busy_q <= (from_i < to_i);
    end else if (busy_q) begin
      cur_q <= cur_inc;
      if (cur_inc >= end_q) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign addr_o = cur_q;
endmodule

// File: rtl/cmd_packer.sv
module cmd_packer
  import cmdpk_pkg::*;
#(
  parameter int DEPTH      = 2048,
  parameter int LINE_BYTES = 64,
  localparam int AW        = $clog2(DEPTH),
  localparam int FP_W      = AW + 2,
  localparam int TAIL_W    = FP_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_indexed_i,
  input  logic [19:0]       req_offset_i,
  input  logic [31:0]       req_data_i,
  output logic              req_ready_o,
  input  logic              commit_i,
  output logic              ram_we_o,
  output logic [AW-1:0]     ram_addr_o,
  output logic [31:0]       ram_wdata_o,
  output logic [FP_W-1:0]   free_pos_o,
  output logic [TAIL_W-1:0] tail_o,
  output logic              tail_valid_o,
  output logic              overflow_o
);
  localparam int LINE_WORDS = LINE_BYTES / 4;
  localparam int LW_LOG     = $clog2(LINE_WORDS);

  logic [FP_W-1:0]  free_q, ins_q, count_q;
  logic             cur_valid_q;
  logic [OFF_W-1:0] cur_off_q;
  logic             ovf_q;
  logic [TAIL_W-1:0] tail_q;
  logic             tail_vld_q;

  req_kind_e                        kind;
  logic [NW_W-1:0]                  n_words;
  logic [MAX_WORDS-1:0][FP_W-1:0]   w_addr;
  logic [MAX_WORDS-1:0][DATA_W-1:0] w_data;
  logic [FP_W-1:0]                  free_nxt, ins_nxt, count_nxt;

  logic             seq_busy, fill_busy;
  logic [FP_W-1:0]  seq_addr, fill_addr, wr_addr;
  logic [DATA_W-1:0] seq_data;
  logic             req_acc, com_acc, com_live;
  logic [FP_W-1:0]  line_up, tail_words;

  assign req_ready_o = !seq_busy && !fill_busy;
  assign com_acc     = commit_i && req_ready_o;
  assign req_acc     = req_valid_i && req_ready_o && !commit_i;
  assign com_live    = com_acc && (free_q != '0);

  assign line_up    = free_q + FP_W'(LINE_WORDS - 1);
  assign tail_words = {line_up[FP_W-1:LW_LOG], {LW_LOG{1'b0}}};

  cmdpk_planner #(.DEPTH(DEPTH), .FP_W(FP_W)) u_plan (
    .req_indexed_i (req_indexed_i),
    .req_offset_i  (req_offset_i),
    .req_data_i    (req_data_i),
    .free_i        (free_q),
    .ins_i         (ins_q),
    .cur_valid_i   (cur_valid_q),
    .cur_off_i     (cur_off_q),
    .count_i       (count_q),
    .kind_o        (kind),
    .n_words_o     (n_words),
    .w_addr_o      (w_addr),
    .w_data_o      (w_data),
    .free_nxt_o    (free_nxt),
    .ins_nxt_o     (ins_nxt),
    .count_nxt_o   (count_nxt)
  );

  cmdpk_word_seq #(.FP_W(FP_W)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (req_acc && (kind != KIND_DROP)),
    .n_i    (n_words),
    .addr_i (w_addr),
    .data_i (w_data),
    .busy_o (seq_busy),
    .addr_o (seq_addr),
    .data_o (seq_data)
  );

  cmdpk_line_fill #(.FP_W(FP_W)) u_fill (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (com_live),
    .from_i  (free_q),
    .to_i    (tail_words),
    .busy_o  (fill_busy),
    .addr_o  (fill_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      free_q      <= '0;
      ins_q       <= '0;
      count_q     <= '0;
      cur_valid_q <= 1'b0;
      cur_off_q   <= '0;
      ovf_q       <= 1'b0;
      tail_q      <= '0;
      tail_vld_q  <= 1'b0;
    end else begin
      tail_vld_q <= com_live;
      if (com_live) begin
        tail_q      <= {tail_words, 2'b00};
        free_q      <= '0;
        ins_q       <= '0;
        count_q     <= '0;
        cur_valid_q <= 1'b0;
        ovf_q       <= 1'b0;
      end else if (req_acc) begin
        if (kind == KIND_DROP) begin
          ovf_q <= 1'b1;
        end else begin
          free_q  <= free_nxt;
          ins_q   <= ins_nxt;
          count_q <= count_nxt;
          // a direct write must never be extended as a burst
          cur_valid_q <= (kind != KIND_DIRECT);
          if (kind == KIND_OPEN) cur_off_q <= req_offset_i;
        end
      end
    end
  end

  assign wr_addr     = seq_busy ? seq_addr : fill_addr;
  assign ram_we_o    = (seq_busy || fill_busy) && (wr_addr < FP_W'(DEPTH));
  assign ram_addr_o  = wr_addr[AW-1:0];
  assign ram_wdata_o = seq_busy ? seq_data : '0;

  assign free_pos_o   = free_q;
  assign tail_o       = tail_q;
  assign tail_valid_o = tail_vld_q;
  assign overflow_o   = ovf_q;
endmodule

// File: rtl/cmd_packer_chk.sv
module cmd_packer_chk #(
  parameter int DEPTH      = 2048,
  parameter int LINE_BYTES = 64,
  parameter int FP_W       = 13,
  parameter int TAIL_W     = 15
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_indexed_i,
  input logic              req_ready_o,
  input logic              commit_i,
  input logic              ram_we_o,
  input logic [FP_W-1:0]   free_pos_o,
  input logic [TAIL_W-1:0] tail_o,
  input logic              tail_valid_o,
  input logic              overflow_o
);
  logic req_acc, com_acc;
  assign req_acc = req_valid_i && req_ready_o && !commit_i;
  assign com_acc = commit_i && req_ready_o;

  AST_DIRECT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_acc && !req_indexed_i && (free_pos_o < FP_W'(DEPTH)) |=> free_pos_o == $past(free_pos_o) + FP_W'(2)); // R1
  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_acc && (free_pos_o >= FP_W'(DEPTH)) |=> overflow_o && $stable(free_pos_o) && !ram_we_o); // R5
  AST_TAIL_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tail_valid_o |-> (tail_o != '0) && ((tail_o % TAIL_W'(LINE_BYTES)) == '0)); // R6
  AST_COMMIT_REWIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    com_acc && (free_pos_o != '0) |=> (free_pos_o == '0) && tail_valid_o && !overflow_o); // R8
  AST_EMPTY_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    com_acc && (free_pos_o == '0) |=> !tail_valid_o && !ram_we_o && (free_pos_o == '0)); // R9
  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> !req_ready_o); // R10
  AST_FIRST_WORD_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_acc && (free_pos_o < FP_W'(DEPTH - 1)) |=> ram_we_o); // R10
endmodule

bind cmd_packer cmd_packer_chk #(
  .DEPTH(DEPTH), .LINE_BYTES(LINE_BYTES), .FP_W(FP_W), .TAIL_W(TAIL_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_indexed_i (req_indexed_i),
  .req_ready_o   (req_ready_o),
  .commit_i      (commit_i),
  .ram_we_o      (ram_we_o),
  .free_pos_o    (free_pos_o),
  .tail_o        (tail_o),
  .tail_valid_o  (tail_valid_o),
  .overflow_o    (overflow_o)
);

// File: tb/cmd_packer_tb_top.sv
`timescale 1ns/1ps
module cmd_packer_tb_top;
  localparam int DEPTH = 2048;
  localparam int unsigned SENT = 32'hA5A5_5A5A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_indexed = 1'b0;
  logic [19:0] req_offset = '0;
  logic [31:0] req_data = '0;
  logic        req_ready;
  logic        commit = 1'b0;
  logic        ram_we;
  logic [10:0] ram_addr;
  logic [31:0] ram_wdata;
  logic [12:0] free_pos;
  logic [14:0] tail;
  logic        tail_valid;
  logic        overflow;

  int checks = 0;
  int errors = 0;

  int unsigned exp_mem[DEPTH];
  int unsigned got_mem[DEPTH];
  int m_free, m_ins, m_cnt, m_first;
  bit m_cv, m_ovf;
  int unsigned m_off;

  always #4 clk = ~clk;

  cmd_packer dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_indexed_i(req_indexed),
    .req_offset_i(req_offset), .req_data_i(req_data),
    .req_ready_o(req_ready), .commit_i(commit),
    .ram_we_o(ram_we), .ram_addr_o(ram_addr), .ram_wdata_o(ram_wdata),
    .free_pos_o(free_pos), .tail_o(tail), .tail_valid_o(tail_valid),
    .overflow_o(overflow)
  );

  always @(negedge clk) if (ram_we) got_mem[ram_addr] = ram_wdata;

  function automatic void chk(bit ok, string req, int unsigned act, int unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endfunction

  function automatic void mw(int a, int unsigned d);
    if (a < DEPTH) exp_mem[a] = d;
  endfunction

  function automatic void model_req(bit idx, int unsigned off, int unsigned d);
    int s;
    m_first = -1;
    if (m_free >= DEPTH) begin
      m_ovf = 1'b1;
      return;
    end
    if (!idx) begin
      s = m_free;
      mw(s, d);
      mw(s + 1, 32'h01F0_0000 | off);
      m_ins = s; m_free = s + 2; m_cv = 1'b0; m_first = s;
    end else if (m_cv && off == m_off) begin
      m_first = m_free;
      mw(m_free, d);
      m_cnt++;
      mw(m_ins, m_cnt);
      m_free++;
      if (m_free % 2 == 1) mw(m_free, 0);
    end else begin
      s = (m_free + 1) & ~1;
      mw(s, 1);
      mw(s + 1, 32'h0900_0000 | off);
      mw(s + 2, d);
      mw(s + 3, 0);
      m_free = s + 3; m_ins = s; m_cnt = 1; m_cv = 1'b1; m_off = off; m_first = s;
    end
  endfunction

  function automatic int img_diff();
    int n = 0;
    for (int a = 0; a < DEPTH; a++)
      if (got_mem[a] != exp_mem[a]) begin
        if (n == 0) $display("  word %0d differs: got %0h exp %0h", a, got_mem[a], exp_mem[a]);
        n++;
      end
    return n;
  endfunction

  task automatic do_req(bit idx, int unsigned off, int unsigned d, string tag);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_indexed = idx; req_offset = off[19:0]; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    model_req(idx, off, d);
    chk(int'(free_pos) == m_free, tag, free_pos, m_free);
    chk(overflow == m_ovf, "R5", overflow, m_ovf);
    if (m_first >= 0 && m_first < DEPTH)
      chk(ram_we && int'(ram_addr) == m_first, "R10", {ram_we, 20'h0, ram_addr}, m_first);
    else
      chk(!ram_we, "R12", ram_we, 0);
  endtask

  task automatic do_commit(bit with_req);
    int tw;
    while (!req_ready) @(negedge clk);
    commit = 1'b1;
    if (with_req) begin
      req_valid = 1'b1; req_indexed = 1'b0; req_offset = 20'h3FF; req_data = 32'hBAD;
    end
    @(negedge clk);
    commit = 1'b0; req_valid = 1'b0;
    if (m_free == 0) begin
      chk(!tail_valid && !ram_we, "R9", {tail_valid, ram_we}, 0);
    end else begin
      tw = ((m_free + 15) / 16) * 16;
      chk(tail_valid && int'(tail) == tw * 4, "R6", tail, tw * 4);
      for (int a = m_free; a < tw; a++) mw(a, 0);
    end
    m_free = 0; m_ins = 0; m_cnt = 0; m_cv = 1'b0; m_ovf = 1'b0;
    while (!req_ready) @(negedge clk);
    chk(img_diff() == 0, "R7", 1, 0);
    chk(free_pos == 0, with_req ? "R10" : "R8", free_pos, 0);
    chk(!overflow, "R5", overflow, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned offs[4];
    offs[0] = 20'h100; offs[1] = 20'h104; offs[2] = 20'h7FFFC; offs[3] = 20'h200;
    for (int a = 0; a < DEPTH; a++) begin exp_mem[a] = SENT; got_mem[a] = SENT; end
    m_free = 0; m_ins = 0; m_cnt = 0; m_cv = 1'b0; m_ovf = 1'b0; m_off = 0;
    void'($urandom(32'd1234));

    repeat (3) @(negedge clk);
    chk(free_pos == 0 && !ram_we && !tail_valid && !overflow, "R11",
        {free_pos, ram_we, tail_valid, overflow}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && free_pos == 0, "R11", {req_ready, free_pos}, 32'h2000);

    // directed layout sequence
    do_req(1'b0, 20'h100, 32'h1111_0001, "R1");
    do_req(1'b1, 20'h100, 32'h2222_0001, "R4");
    chk(free_pos == 5, "R4", free_pos, 5);
    do_req(1'b1, 20'h100, 32'h2222_0002, "R3");
    do_req(1'b1, 20'h100, 32'h2222_0003, "R3");
    do_req(1'b1, 20'h104, 32'h3333_0001, "R2");
    chk(free_pos == 11, "R2", free_pos, 11);
    do_req(1'b0, 20'h104, 32'h4444_0001, "R1");
    do_req(1'b1, 20'h104, 32'h5555_0001, "R4");
    chk(free_pos == 17, "R2", free_pos, 17);
    do_commit(1'b0);

    // empty commit
    do_commit(1'b0);

    // commit wins over a simultaneous request
    do_req(1'b0, 20'h010, 32'h6666_0001, "R1");
    do_commit(1'b1);

    // fresh run after commit opens at word 0
    do_req(1'b1, 20'h104, 32'h7777_0001, "R8");
    chk(free_pos == 3, "R8", free_pos, 3);
    do_commit(1'b0);

    // exactly one line, no fill
    for (int i = 0; i < 8; i++) do_req(1'b0, 20'h020 + i * 4, 32'h8000_0000 + i, "R1");
    do_commit(1'b0);

    // random mix
    for (int r = 0; r < 25; r++) begin
      int n = 1 + int'($urandom % 40);
      for (int i = 0; i < n; i++) begin
        bit ix = ($urandom % 10) < 7;
        do_req(ix, offs[$urandom % 4], $urandom, ix ? "R3" : "R1");
      end
      do_commit(1'b0);
    end

    // fill to capacity, overflow and suppressed writes
    for (int i = 0; i < 1023; i++) do_req(1'b0, 20'h040, i, "R1");
    do_req(1'b1, 20'h080, 32'h9999_0001, "R12");
    chk(free_pos == 2049, "R12", free_pos, 2049);
    do_req(1'b0, 20'h084, 32'h9999_0002, "R5");
    do_req(1'b1, 20'h080, 32'h9999_0003, "R5");
    chk(overflow && free_pos == 2049, "R5", {overflow, free_pos}, 32'h2801);
    do_commit(1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule